// File: doc/BRIEF.md
# Instruction Byte Stream Decoder

This block takes machine code for a small 8-bit microcontroller instruction set one byte at a time and turns it into decoded instruction records. It does not rely on a fixed field layout. It works out each instruction's boundaries by parsing the stream in order. It reads an opcode, or a prefix byte and then an opcode, and from that knows how many operand bytes follow. It collects those bytes into a 16-bit operand value. When the last byte of an instruction arrives, it pulses an output record for one cycle.

The opcode set is a subset of the instruction set:

- the no-operation instruction;
- load, add and store for accumulators A, B and the 16-bit pair D, in immediate, direct and extended forms;
- the prefixed increment of index register Y.

Any other opcode pulses an error output. The offending byte is discarded, and the next byte is treated as a fresh opcode.

The block sits between a code fetch stream and anything that needs an instruction-level view, such as a trace unit or a disassembly monitor. It never stalls its input.

Top module: `opstream_decoder`

## Requirements
- R1: `in_ready` is 1 in every cycle after reset, and a byte is consumed on each rising edge where `in_valid` is 1.
- R2: Opcodes map to these mnemonic codes: 01 gives 0 (NOP); 86/96/B6 give 1 (LDAA); C6/D6 give 2 (LDAB); CC/DC give 3 (LDD); 8B/9B/BB give 4 (ADDA); CB/DB give 5 (ADDB); C3/D3 give 6 (ADDD); 97/B7 give 7 (STAA); D7 gives 8 (STAB); DD gives 9 (STD).
- R3: Mode codes are 0 for inherent, 1 for immediate, 2 for direct and 3 for extended. Opcodes 86/C6/CC/8B/CB/C3 are immediate, 96/D6/DC/9B/DB/D3/97/D7/DD are direct, B6/BB/B7 are extended, and 01 is inherent.
- R4: The number of operand bytes depends on the form. Direct takes 1. Extended takes 2. Immediate takes 2 for LDD and ADDD and 1 for the other immediate opcodes. Bytes are assembled most significant first, and a single operand byte is zero-extended to 16 bits.
- R5: `out_len` is the total instruction length in bytes, opcode and prefix included.
- R6: The byte 18 followed by 08 decodes as mnemonic 10 (INY), mode 0, length 2.
- R7: A byte in opcode position that is neither known nor 18 pulses `out_err` for one cycle and gives no record. Decoding resumes with the next byte as an opcode.
- R8: After 18, any byte other than 08 pulses `out_err`. Both that byte and the prefix are discarded, and the next byte is an opcode.
- R9: Operand bytes are never decoded as opcodes. Cycles with `in_valid` at 0 inside an instruction neither advance decoding nor produce output.
- R10: `out_valid` and `out_err` rise in the cycle after the rising edge that consumed the deciding byte, and each lasts exactly one cycle for that byte.
- R11: Reset clears both pulse outputs and abandons any partly received instruction.
- R12: Instructions with mode 0 report an operand of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Block accepts a byte (always 1 after reset) |
| in_byte | input | 8 | Machine-code byte |
| out_valid | output | 1 | One-cycle pulse: a decoded record is present |
| out_mnem | output | 4 | Mnemonic code (R2, R6) |
| out_mode | output | 2 | Addressing mode code (R3) |
| out_operand | output | 16 | Assembled operand value |
| out_len | output | 3 | Instruction length in bytes |
| out_err | output | 1 | One-cycle pulse: byte rejected |

## Verification
The checker assumes that every byte offered with `in_valid` high is consumed at that edge. It also assumes that the record fields are meaningful only while `out_valid` is high. It therefore relates each pulse to an accepted byte in the previous cycle, and constrains the record fields only during a pulse.

The stimulus drives inputs on falling edges only and never changes `in_valid` mid-cycle. It includes idle gaps inside instructions, so that the stall behaviour is exercised without breaking either assumption. A reset partway through an instruction is applied only while the bench holds `in_valid` low.

// File: rtl/opdec_pkg.sv
package opdec_pkg;
    localparam int BYTE_W  = 8;
    localparam int OPND_W  = 16;
    localparam int LEN_W   = 3;
    localparam int CNT_W   = 2;

    localparam logic [BYTE_W-1:0] PFX_Y_CODE = 8'h18;

    typedef enum logic [3:0] {
        MN_NOP  = 4'd0,
        MN_LDAA = 4'd1,
        MN_LDAB = 4'd2,
        MN_LDD  = 4'd3,
        MN_ADDA = 4'd4,
        MN_ADDB = 4'd5,
        MN_ADDD = 4'd6,
        MN_STAA = 4'd7,
        MN_STAB = 4'd8,
        MN_STD  = 4'd9,
        MN_INY  = 4'd10
    } mnem_e;

    typedef enum logic [1:0] {
        AM_INH = 2'd0,
        AM_IMM = 2'd1,
        AM_DIR = 2'd2,
        AM_EXT = 2'd3
    } amode_e;

    typedef struct packed {
        logic             known;
        mnem_e            mnem;
        amode_e           mode;
        logic [CNT_W-1:0] nopnd;
    } op_info_t;

    typedef enum logic [1:0] {
        ST_OPCODE = 2'd0,
        ST_PREFIX = 2'd1,
        ST_OPERAND = 2'd2
    } dec_state_e;
endpackage

// File: rtl/opdec_lookup.sv
module opdec_lookup
    import opdec_pkg::*;
(
    input  logic [BYTE_W-1:0] code,
    input  logic              prefixed,
    output op_info_t          info
);
    function automatic op_info_t mk(input mnem_e m, input amode_e a, input int n);
        op_info_t r;
        r.known = 1'b1;
        r.mnem  = m;
        r.mode  = a;
        r.nopnd = CNT_W'(n);
        return r;
    endfunction

    always_comb begin
        info = '{known: 1'b0, mnem: MN_NOP, mode: AM_INH, nopnd: '0};
        if (prefixed) begin
            case (code)
                8'h08:   info = mk(MN_INY, AM_INH, 0);
                default: ;
            endcase
        end else begin
            case (code)
                8'h01: info = mk(MN_NOP,  AM_INH, 0);
                8'h86: info = mk(MN_LDAA, AM_IMM, 1);
                8'h96: info = mk(MN_LDAA, AM_DIR, 1);
                8'hB6: info = mk(MN_LDAA, AM_EXT, 2);
                8'hC6: info = mk(MN_LDAB, AM_IMM, 1);
                8'hD6: info = mk(MN_LDAB, AM_DIR, 1);
                8'hCC: info = mk(MN_LDD,  AM_IMM, 2);
                8'hDC: info = mk(MN_LDD,  AM_DIR, 1);
                8'h8B: info = mk(MN_ADDA, AM_IMM, 1);
                8'h9B: info = mk(MN_ADDA, AM_DIR, 1);
                8'hBB: info = mk(MN_ADDA, AM_EXT, 2);
                8'hCB: info = mk(MN_ADDB, AM_IMM, 1);
                8'hDB: info = mk(MN_ADDB, AM_DIR, 1);
                8'hC3: info = mk(MN_ADDD, AM_IMM, 2);
                8'hD3: info = mk(MN_ADDD, AM_DIR, 1);
                8'h97: info = mk(MN_STAA, AM_DIR, 1);
                8'hB7: info = mk(MN_STAA, AM_EXT, 2);
                8'hD7: info = mk(MN_STAB, AM_DIR, 1);
                8'hDD: info = mk(MN_STD,  AM_DIR, 1);
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/opdec_operand.sv
module opdec_operand
    import opdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CNT_W-1:0]  load_cnt,
    input  logic              shift,
    input  logic [BYTE_W-1:0] din,
    output logic [CNT_W-1:0]  remain,
    output logic [OPND_W-1:0] value
);
    typedef struct packed {
        logic [CNT_W-1:0]  remain;
        logic [OPND_W-1:0] value;
    } acc_t;

    acc_t acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        if (load) begin
            acc_d.remain = load_cnt;
            acc_d.value  = '0;
        end else if (shift && acc_q.remain != '0) begin
            acc_d.remain = acc_q.remain - 1'b1;
            acc_d.value  = {acc_q.value[OPND_W-BYTE_W-1:0], din};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign remain = acc_q.remain;
    assign value  = acc_q.value;
endmodule

// File: rtl/opstream_decoder.sv
module opstream_decoder
    import opdec_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [7:0]  in_byte,
    output logic        out_valid,
    output logic [3:0]  out_mnem,
    output logic [1:0]  out_mode,
    output logic [15:0] out_operand,
    output logic [2:0]  out_len,
    output logic        out_err
);
    typedef struct packed {
        dec_state_e        state;
        mnem_e             cur_mnem;
        amode_e            cur_mode;
        logic [LEN_W-1:0]  cur_len;
        logic              valid;
        logic              err;
        mnem_e             mnem;
        amode_e            mode;
        logic [OPND_W-1:0] operand;
        logic [LEN_W-1:0]  len;
    } dec_t;

    dec_t dec_d, dec_q;

    op_info_t          info;
    logic              take;
    logic              opnd_load;
    logic [CNT_W-1:0]  opnd_cnt;
    logic              opnd_shift;
    logic [CNT_W-1:0]  opnd_remain;
    logic [OPND_W-1:0] opnd_value;

    assign in_ready = 1'b1;
    assign take     = in_valid;

    opdec_lookup u_lookup (
        .code     (in_byte),
        .prefixed (dec_q.state == ST_PREFIX),
        .info     (info)
    );

    opdec_operand u_operand (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (opnd_load),
        .load_cnt (opnd_cnt),
        .shift    (opnd_shift),
        .din      (in_byte),
        .remain   (opnd_remain),
        .value    (opnd_value)
    );

    always_comb begin
        dec_d       = dec_q;
        dec_d.valid = 1'b0;
        dec_d.err   = 1'b0;
        opnd_load   = 1'b0;
        opnd_cnt    = info.nopnd;
        opnd_shift  = 1'b0;

        if (take) begin
            case (dec_q.state)
                ST_OPCODE, ST_PREFIX: begin
                    if (dec_q.state == ST_OPCODE && in_byte == PFX_Y_CODE) begin
                        dec_d.state = ST_PREFIX;
                    end else if (info.known) begin
                        dec_d.cur_mnem = info.mnem;
                        dec_d.cur_mode = info.mode;
                        dec_d.cur_len  = LEN_W'(info.nopnd)
                                       + ((dec_q.state == ST_PREFIX) ? LEN_W'(2) : LEN_W'(1));
                        if (info.nopnd == '0) begin
                            dec_d.valid   = 1'b1;
                            dec_d.mnem    = info.mnem;
                            dec_d.mode    = info.mode;
                            dec_d.operand = '0;
                            dec_d.len     = dec_d.cur_len;
                            dec_d.state   = ST_OPCODE;
                        end else begin
                            opnd_load   = 1'b1;
                            dec_d.state = ST_OPERAND;
                        end
                    end else begin
                        dec_d.err   = 1'b1;
                        dec_d.state = ST_OPCODE;
                    end
                end
                ST_OPERAND: begin
                    opnd_shift = 1'b1;
                    if (opnd_remain == CNT_W'(1)) begin
                        dec_d.valid   = 1'b1;
                        dec_d.mnem    = dec_q.cur_mnem;
                        dec_d.mode    = dec_q.cur_mode;
                        dec_d.operand = {opnd_value[OPND_W-BYTE_W-1:0], in_byte};
                        dec_d.len     = dec_q.cur_len;
                        dec_d.state   = ST_OPCODE;
                    end
                end
                default: dec_d.state = ST_OPCODE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dec_q <= '{state: ST_OPCODE, cur_mnem: MN_NOP, cur_mode: AM_INH,
                              cur_len: '0, valid: 1'b0, err: 1'b0, mnem: MN_NOP,
                              mode: AM_INH, operand: '0, len: '0};
        else        dec_q <= dec_d;
    end

    assign out_valid   = dec_q.valid;
    assign out_err     = dec_q.err;
    assign out_mnem    = dec_q.mnem;
    assign out_mode    = dec_q.mode;
    assign out_operand = dec_q.operand;
    assign out_len     = dec_q.len;
endmodule

// File: rtl/opstream_decoder_chk.sv
module opstream_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_ready,
    input logic        out_valid,
    input logic [3:0]  out_mnem,
    input logic [1:0]  out_mode,
    input logic [15:0] out_operand,
    input logic [2:0]  out_len,
    input logic        out_err
);
    // R10
    valid_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid && in_ready));

    // R7
    err_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> $past(in_valid && in_ready));

    // R7
    err_not_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && out_err));

    // R12
    inherent_zero_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_mode == 2'd0) |-> out_operand == 16'h0000);

    // R5
    extended_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_mode == 2'd3) |-> out_len == 3'd3);

    // R6
    iny_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_mnem == 4'd10) |-> (out_len == 3'd2 && out_mode == 2'd0));

    // R4
    narrow_immediate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_mode == 2'd1 && out_mnem != 4'd3 && out_mnem != 4'd6)
            |-> out_operand[15:8] == 8'h00);
endmodule

bind opstream_decoder opstream_decoder_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_mnem    (out_mnem),
    .out_mode    (out_mode),
    .out_operand (out_operand),
    .out_len     (out_len),
    .out_err     (out_err)
);

// File: tb/opstream_decoder_bench.sv
module opstream_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_byte = 8'h00;
    logic        out_valid;
    logic [3:0]  out_mnem;
    logic [1:0]  out_mode;
    logic [15:0] out_operand;
    logic [2:0]  out_len;
    logic        out_err;

    int n_total = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    opstream_decoder u_opstream_decoder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_byte(in_byte), .out_valid(out_valid), .out_mnem(out_mnem),
        .out_mode(out_mode), .out_operand(out_operand), .out_len(out_len),
        .out_err(out_err)
    );

    // entry: byte, expect valid, expect err, mnem, mode, operand, len
    function automatic logic [34:0] ve(input logic [7:0] b, input logic v, input logic e,
                                       input logic [3:0] m, input logic [1:0] a,
                                       input logic [15:0] o, input logic [2:0] l);
        return {b, v, e, m, a, o, l};
    endfunction

    localparam int NV = 46;
    localparam logic [34:0] VEC [NV] = '{
        ve(8'h96,0,0,0,0,16'h0000,0), ve(8'h30,1,0,1,2,16'h0030,2),
        ve(8'h8B,0,0,0,0,16'h0000,0), ve(8'h07,1,0,4,1,16'h0007,2),
        ve(8'h97,0,0,0,0,16'h0000,0), ve(8'h30,1,0,7,2,16'h0030,2),
        ve(8'h01,1,0,0,0,16'h0000,1),
        ve(8'hB6,0,0,0,0,16'h0000,0), ve(8'h20,0,0,0,0,16'h0000,0), ve(8'h00,1,0,1,3,16'h2000,3),
        ve(8'hCC,0,0,0,0,16'h0000,0), ve(8'h12,0,0,0,0,16'h0000,0), ve(8'h34,1,0,3,1,16'h1234,3),
        ve(8'h18,0,0,0,0,16'h0000,0), ve(8'h08,1,0,10,0,16'h0000,2),
        ve(8'hFF,0,1,0,0,16'h0000,0),
        ve(8'hC6,0,0,0,0,16'h0000,0), ve(8'h5A,1,0,2,1,16'h005A,2),
        ve(8'h18,0,0,0,0,16'h0000,0), ve(8'h86,0,1,0,0,16'h0000,0),
        ve(8'hBB,0,0,0,0,16'h0000,0), ve(8'hAB,0,0,0,0,16'h0000,0), ve(8'hCD,1,0,4,3,16'hABCD,3),
        ve(8'hC3,0,0,0,0,16'h0000,0), ve(8'h00,0,0,0,0,16'h0000,0), ve(8'hFF,1,0,6,1,16'h00FF,3),
        ve(8'hDD,0,0,0,0,16'h0000,0), ve(8'h80,1,0,9,2,16'h0080,2),
        ve(8'hD7,0,0,0,0,16'h0000,0), ve(8'h01,1,0,8,2,16'h0001,2),
        ve(8'hB7,0,0,0,0,16'h0000,0), ve(8'hFF,0,0,0,0,16'h0000,0), ve(8'hEE,1,0,7,3,16'hFFEE,3),
        ve(8'hCB,0,0,0,0,16'h0000,0), ve(8'h18,1,0,5,1,16'h0018,2),
        ve(8'hD3,0,0,0,0,16'h0000,0), ve(8'h44,1,0,6,2,16'h0044,2),
        ve(8'hDC,0,0,0,0,16'h0000,0), ve(8'h55,1,0,3,2,16'h0055,2),
        ve(8'hD6,0,0,0,0,16'h0000,0), ve(8'h66,1,0,2,2,16'h0066,2),
        ve(8'h9B,0,0,0,0,16'h0000,0), ve(8'h77,1,0,4,2,16'h0077,2),
        ve(8'hDB,0,0,0,0,16'h0000,0), ve(8'h88,1,0,5,2,16'h0088,2),
        ve(8'h00,0,1,0,0,16'h0000,0)
    };

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk);
        #1;
    endtask

    task automatic chk_record(input string req, input logic [3:0] m, input logic [1:0] a,
                              input logic [15:0] o, input logic [2:0] l);
        chk(out_valid === 1'b1 && out_err === 1'b0, req, {out_valid, out_err}, 2'b10);
        chk({out_mnem, out_mode, out_operand, out_len} === {m, a, o, l}, req,
            {out_mnem, out_mode, out_operand, out_len}, {m, a, o, l});
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_total++;
        n_fail++;
        $display("FAIL R10: watchdog expired, actual running expected done");
        summary();
        $finish;
    end

    initial begin
        // R11 reset state
        #1;
        chk(out_valid === 1'b0 && out_err === 1'b0, "R11", {out_valid, out_err}, 2'b00);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 ready after reset
        chk(in_ready === 1'b1, "R1", in_ready, 1'b1);

        // R2 R3 R4 R5 R6 R7 R8 R9 R10 R12: table walk
        for (int i = 0; i < NV; i++) begin
            logic [34:0] v;
            v = VEC[i];
            send(v[34:27]);
            chk(out_valid === v[26] && out_err === v[25], "R7/R10 pulse",
                {out_valid, out_err}, {v[26], v[25]});
            if (v[26])
                chk({out_mnem, out_mode, out_operand, out_len} === v[24:0], "R2/R3/R4/R5",
                    {out_mnem, out_mode, out_operand, out_len}, v[24:0]);
        end
        idle();
        chk(out_valid === 1'b0 && out_err === 1'b0, "R10 one-cycle pulse",
            {out_valid, out_err}, 2'b00);

        // R9 gaps inside an extended instruction
        send(8'hB6);
        for (int k = 0; k < 3; k++) begin
            idle();
            chk(out_valid === 1'b0, "R9 stall", out_valid, 1'b0);
        end
        send(8'h12);
        idle();
        idle();
        chk(out_valid === 1'b0, "R9 stall", out_valid, 1'b0);
        send(8'h34);
        chk_record("R9", 4'd1, 2'd3, 16'h1234, 3'd3);
        idle();

        // R11 reset abandons a partial instruction
        send(8'hCC);
        send(8'h11);
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        #1;
        chk(out_valid === 1'b0 && out_err === 1'b0, "R11", {out_valid, out_err}, 2'b00);
        @(negedge clk);
        rst_n = 1'b1;
        send(8'h01);
        chk_record("R11", 4'd0, 2'd0, 16'h0000, 3'd1);

        // R8 prefix followed by another prefix byte
        send(8'h18);
        send(8'h18);
        chk(out_err === 1'b1 && out_valid === 1'b0, "R8", {out_valid, out_err}, 2'b01);
        send(8'h08);
        chk(out_err === 1'b1, "R8 prefix discarded", out_err, 1'b1);
        send(8'h18);
        send(8'h08);
        chk_record("R6", 4'd10, 2'd0, 16'h0000, 3'd2);
        idle();

        summary();
        $finish;
    end
endmodule